// File: doc/BRIEF.md
# Register-Controlled Clock Divider with Stop and Source Select

The block makes a divided clock signal from one of several source tick streams. The ticks are single-cycle strobes that are synchronous to the block clock. Software controls it through one 32-bit control image on a synchronous write/read port. The image holds a divide ratio (stored as ratio minus one, from 1 to 64), a stop bit, and a source-select field. The position of the select field depends on how many sources the instance is built with.

The output is a registered level, so every change of the output happens on a block clock edge. For a ratio above one, the output is high for half the source ticks of a period, rounded down, and low for the rest. For a ratio of one, the output goes high for one cycle after each tick of the selected source.

Stopping, restarting, ratio changes and source changes are all timed against the output waveform, so no shortened pulse ever appears:
- A stop lets the current high phase finish.
- A new ratio is taken up only at the start of a period.
- A source change waits until the output is parked low, and only then swaps the source.

Top module: `dcg_top`

## Requirements
- R1: After reset the control image reads 0x0000013F (ratio field 63, stop bit 8 set, source 0), `enabled` is 0 and `div_out` is low.
- R2: Bits [5:0] hold the ratio minus one. While running, one output period spans (field+1) ticks of the selected source.
- R3: For a ratio D>1 the output is high for floor(D/2) ticks and low for D-floor(D/2) ticks. For D=1 the output is high for exactly the one cycle after each selected tick. A rising edge of `div_out` always comes in the cycle after a selected tick.
- R4: Setting stop (bit 8) lets the current high phase finish, then holds `div_out` low with no rising edge. Clearing stop makes the output resume, starting with a high phase at the next selected tick.
- R5: `enabled` always equals the inverse of bit 8 of the control image.
- R6: A write that sets stop with a zero ratio field stores 63 in the field. A write that sets stop with a nonzero field keeps that field. A write that clears stop loads the written ratio field and clears stop in that single write.
- R7: The source field is bits [7:6] when NSRC=4 and bits [14:12] when NSRC=8. With NSRC=1 there is no source field and those bits read zero.
- R8: A ratio written mid-period does not alter the period in progress. The new ratio takes effect from the next period start.
- R9: On a source change the output is parked low before the active source switches, and the active source never changes while the output is high or has just fallen. Afterwards the period is counted in ticks of the new source.
- R10: Bits outside the ratio, stop and source fields read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control image |
| wr_data | input | 32 | Data to write |
| rd_data | output | 32 | Current control image |
| src_tick | input | NSRC | One tick strobe per source |
| div_out | output | 1 | Divided, stop-gated output level |
| enabled | output | 1 | Run status: inverse of the stop bit |

## Verification
The assertions check on every cycle the rules that follow from the control image and from edge timing:
- a stored stop always comes with a nonzero ratio field;
- the status output mirrors the stop bit;
- unused bits stay zero;
- no rising edge appears without a preceding selected tick, or while stop is set;
- the active source changes only while the output is parked low.

The bench scenarios are needed for what only shows over many cycles:
- the measured high and low lengths for random ratios and source rates;
- a ratio rewritten mid-period, which must leave the running period intact;
- the stop and restart sequence;
- the exact image values produced by the write-merge rules.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

    localparam int REG_W    = 32;
    localparam int RATIO_W  = 6;
    localparam int CNT_W    = RATIO_W + 1;
    localparam int STOP_POS = 8;
    localparam logic [REG_W-1:0] RESET_IMAGE = 32'h0000_013F;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio_m1;
        logic               stop;
    } ctl_t;

    function automatic int sel_width(input int nsrc);
        return (nsrc == 8) ? 3 : ((nsrc == 4) ? 2 : 1);
    endfunction

    function automatic int sel_lsb(input int nsrc);
        return (nsrc == 8) ? 12 : 6;
    endfunction

    function automatic logic [REG_W-1:0] used_mask(input int nsrc);
        logic [REG_W-1:0] m;
        m = 32'h0000_013F;
        if (nsrc > 1)
            m = m | (((32'd1 << sel_width(nsrc)) - 32'd1) << sel_lsb(nsrc));
        return m;
    endfunction

    function automatic logic [CNT_W-1:0] high_ticks(input logic [CNT_W-1:0] ratio);
        return ratio >> 1;
    endfunction

    function automatic logic [CNT_W-1:0] low_ticks(input logic [CNT_W-1:0] ratio);
        return ratio - (ratio >> 1);
    endfunction

endpackage

// File: rtl/dcg_regfile.sv
module dcg_regfile
    import dcg_pkg::*;
#(
    parameter int NSRC = 4,
    localparam int SEL_W = sel_width(NSRC),
    localparam int SEL_LSB = sel_lsb(NSRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] image_o,
    output ctl_t             ctl_o,
    output logic [SEL_W-1:0] src_o
);
    localparam logic [REG_W-1:0] MASK = used_mask(NSRC);

    logic [REG_W-1:0] image_q;
    logic [REG_W-1:0] merged;

    // Masked write with the nonzero-ratio-while-stopped rule
    always_comb begin
        merged = wr_data & MASK;
        if (merged[STOP_POS] && (merged[RATIO_W-1:0] == '0))
            merged[RATIO_W-1:0] = '1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            image_q <= RESET_IMAGE;
        else if (wr_en)
            image_q <= merged;
    end

    assign image_o        = image_q;
    assign ctl_o.ratio_m1 = image_q[RATIO_W-1:0];
    assign ctl_o.stop     = image_q[STOP_POS];

    generate
        if (NSRC > 1) begin : g_sel
            assign src_o = image_q[SEL_LSB +: SEL_W];
        end else begin : g_nosel
            assign src_o = '0;
        end
    endgenerate

endmodule

// File: rtl/dcg_src_select.sv
module dcg_src_select
    import dcg_pkg::*;
#(
    parameter int NSRC = 4,
    localparam int SEL_W = sel_width(NSRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_tick,
    input  logic [SEL_W-1:0] req_src,
    input  logic             core_idle,
    output logic             tick_o,
    output logic [SEL_W-1:0] act_src_o,
    output logic             pending_o
);
    generate
        if (NSRC > 1) begin : g_multi
            logic [SEL_W-1:0] act_q;

            always_ff @(posedge clk) begin
                if (rst)
                    act_q <= '0;
                else if ((req_src != act_q) && core_idle)
                    act_q <= req_src;
            end

            assign tick_o    = src_tick[act_q];
            assign act_src_o = act_q;
            assign pending_o = (req_src != act_q);
        end else begin : g_single
            logic unused_in;
            assign unused_in = clk ^ rst ^ core_idle ^ (^req_src);
            assign tick_o    = src_tick[0];
            assign act_src_o = '0;
            assign pending_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/dcg_div_core.sv
module dcg_div_core
    import dcg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [RATIO_W-1:0] ratio_m1,
    input  logic               run_req,
    output logic               out_o,
    output logic               idle_o
);
    logic             run_q;
    logic             out_q;
    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] ratio_q;
    logic [CNT_W-1:0] ratio_new;
    logic             pass_mode;

    assign ratio_new = {1'b0, ratio_m1} + CNT_W'(1);
    assign pass_mode = (ratio_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            out_q   <= 1'b0;
            rem_q   <= CNT_W'(1);
            ratio_q <= CNT_W'(1);
        end else if (!run_q) begin
            out_q <= 1'b0;
            if (run_req && tick) begin
                run_q   <= 1'b1;
                out_q   <= 1'b1;
                ratio_q <= ratio_new;
                rem_q   <= high_ticks(ratio_new);
            end
        end else if (out_q) begin
            if (pass_mode) begin
                if (tick && run_req) begin
                    ratio_q <= ratio_new;
                    rem_q   <= high_ticks(ratio_new);
                end else begin
                    out_q <= 1'b0;
                    rem_q <= CNT_W'(1);
                    if (!run_req)
                        run_q <= 1'b0;
                end
            end else if (tick) begin
                if (rem_q == CNT_W'(1)) begin
                    out_q <= 1'b0;
                    rem_q <= low_ticks(ratio_q);
                    if (!run_req)
                        run_q <= 1'b0;
                end else begin
                    rem_q <= rem_q - CNT_W'(1);
                end
            end
        end else begin
            if (!run_req) begin
                run_q <= 1'b0;
            end else if (tick) begin
                if (rem_q == CNT_W'(1)) begin
                    out_q   <= 1'b1;
                    ratio_q <= ratio_new;
                    rem_q   <= high_ticks(ratio_new);
                end else begin
                    rem_q <= rem_q - CNT_W'(1);
                end
            end
        end
    end

    assign out_o  = out_q;
    assign idle_o = !run_q;

endmodule

// File: rtl/dcg_top.sv
module dcg_top
    import dcg_pkg::*;
#(
    parameter int NSRC = 4,
    localparam int SEL_W = sel_width(NSRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [NSRC-1:0]  src_tick,
    output logic             div_out,
    output logic             enabled
);
    ctl_t             ctl;
    logic [SEL_W-1:0] req_src;
    logic [SEL_W-1:0] act_src;
    logic             sel_tick;
    logic             pending;
    logic             core_idle;

    dcg_regfile #(.NSRC(NSRC)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .image_o (rd_data),
        .ctl_o   (ctl),
        .src_o   (req_src)
    );

    dcg_src_select #(.NSRC(NSRC)) sel_i (
        .clk       (clk),
        .rst       (rst),
        .src_tick  (src_tick),
        .req_src   (req_src),
        .core_idle (core_idle),
        .tick_o    (sel_tick),
        .act_src_o (act_src),
        .pending_o (pending)
    );

    dcg_div_core core_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (sel_tick),
        .ratio_m1 (ctl.ratio_m1),
        .run_req  (!ctl.stop && !pending),
        .out_o    (div_out),
        .idle_o   (core_idle)
    );

    assign enabled = !ctl.stop;

endmodule

// File: rtl/dcg_checker.sv
module dcg_checker
    import dcg_pkg::*;
#(
    parameter int NSRC = 4,
    localparam int SEL_W = sel_width(NSRC)
) (
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] rd_data,
    input logic             enabled,
    input logic             div_out,
    input logic             sel_tick,
    input logic [SEL_W-1:0] act_src
);
    localparam logic [REG_W-1:0] MASK = used_mask(NSRC);

    AST_STOP_FIELD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[STOP_POS] |-> (rd_data[RATIO_W-1:0] != '0)); // R6

    AST_STATUS_INVERSE: assert property (@(posedge clk) disable iff (rst)
        enabled == !rd_data[STOP_POS]); // R5

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~MASK) == '0); // R10

    AST_RISE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(div_out) |-> $past(sel_tick)); // R3

    AST_STOP_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        rd_data[STOP_POS] |=> !$rose(div_out)); // R4

    AST_SWITCH_WHEN_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_src) |-> (!div_out && !$past(div_out))); // R9

endmodule

bind dcg_top dcg_checker #(.NSRC(NSRC)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .rd_data  (rd_data),
    .enabled  (enabled),
    .div_out  (div_out),
    .sel_tick (sel_tick),
    .act_src  (act_src)
);

// File: tb/dcg_top_tb_top.sv
module dcg_top_tb_top;
    localparam int NSRC = 4;
    localparam logic [31:0] MASK = 32'h0000_01FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [NSRC-1:0] src_tick = '0;
    logic        div_out;
    logic        enabled;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    int per [NSRC] = '{1, 2, 3, 5};
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    dcg_top #(.NSRC(NSRC)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .src_tick (src_tick),
        .div_out  (div_out),
        .enabled  (enabled)
    );

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            for (int i = 0; i < NSRC; i++)
                src_tick[i] = ((cyc % per[i]) == 0);
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_image(input logic [31:0] d);
        logic [31:0] m;
        m = d & MASK;
        if (m[8] && m[5:0] == 6'd0) m[5:0] = 6'h3F;
        return m;
    endfunction

    function automatic int exp_hi(input int d, input int t);
        return (d == 1) ? 1 : (d / 2) * t;
    endfunction

    function automatic int exp_lo(input int d, input int t);
        return (d == 1) ? t - 1 : (d - d / 2) * t;
    endfunction

    task automatic write_reg(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_level(input logic lvl, output bit ok);
        int n = 0;
        ok = 1'b1;
        while (div_out !== lvl) begin
            @(negedge clk);
            n++;
            if (n > 3000) begin ok = 1'b0; break; end
        end
    endtask

    task automatic measure(output int hi, output int lo, output bit ok);
        bit ok1, ok2;
        hi = 0; lo = 0;
        wait_level(1'b0, ok1);
        wait_level(1'b1, ok2);
        ok = ok1 && ok2;
        while (ok && div_out === 1'b1 && hi < 3000) begin hi++; @(negedge clk); end
        while (ok && div_out === 1'b0 && lo < 3000) begin lo++; @(negedge clk); end
    endtask

    task automatic run_and_check(input int d, input int s, input string tag);
        int hi, lo;
        bit ok;
        write_reg((32'(s) << 6) | 32'(d - 1));
        check(rd_data == exp_image((32'(s) << 6) | 32'(d - 1)), {tag, " image"},
              rd_data, exp_image((32'(s) << 6) | 32'(d - 1)));
        measure(hi, lo, ok);
        measure(hi, lo, ok);
        measure(hi, lo, ok);
        check(ok && hi == exp_hi(d, per[s]), {tag, " high length"}, hi, exp_hi(d, per[s]));
        check(ok && lo == exp_lo(d, per[s]), {tag, " low length"}, lo, exp_lo(d, per[s]));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int seed_v;
        int hi, lo, t0, t1;
        bit ok, low_ok;
        seed_v = $urandom(32'h5EED);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(rd_data == 32'h0000_013F, "R1 reset image", rd_data, 32'h13F);
        check(enabled == 1'b0, "R1 R5 reset enabled", enabled, 0);
        low_ok = 1'b1;
        repeat (50) begin @(negedge clk); if (div_out !== 1'b0) low_ok = 1'b0; end
        check(low_ok, "R1 R4 output low while stopped", div_out, 0);

        // R10 unused bits and R7 field placement
        write_reg(32'hFFFF_FE00);
        check(rd_data == 32'h0, "R10 unused bits ignored", rd_data, 0);
        write_reg(32'h0000_F1C5);
        check(rd_data == exp_image(32'h0000_F1C5), "R7 source field at [7:6]", rd_data, exp_image(32'h0000_F1C5));

        // R6 stop merge rules
        write_reg(32'h0000_0100);
        check(rd_data == 32'h0000_013F, "R6 stop with zero ratio", rd_data, 32'h13F);
        write_reg(32'h0000_0187);
        check(rd_data == 32'h0000_0187, "R6 stop keeps nonzero ratio", rd_data, 32'h187);
        check(enabled == 1'b0, "R5 stopped status", enabled, 0);

        // R6 restart in one write, R2 R3 shape
        run_and_check(6, 0, "R6 R2 restart ratio 6");
        check(enabled == 1'b1, "R5 running status", enabled, 1);
        run_and_check(7, 0, "R3 odd ratio 7");
        run_and_check(1, 2, "R3 pass mode");
        run_and_check(64, 0, "R2 max ratio 64");
        run_and_check(2, 1, "R2 ratio 2 slow source");

        // R9 source switch
        run_and_check(3, 0, "R9 before switch");
        run_and_check(3, 3, "R9 after switch to source 3");

        // Random ratios and sources
        for (int k = 0; k < 12; k++) begin
            int d, s;
            d = 1 + int'($urandom_range(63, 0));
            s = int'($urandom_range(3, 0));
            if (d == 1 && s == 0) s = 1;
            run_and_check(d, s, "R2 R3 R9 random");
        end

        // R8 mid-period ratio change
        run_and_check(10, 0, "R8 setup ratio 10");
        wait_level(1'b0, ok);
        wait_level(1'b1, ok);
        t0 = cyc;
        repeat (2) @(negedge clk);
        write_reg(32'h0000_0003);
        wait_level(1'b0, ok);
        wait_level(1'b1, ok);
        t1 = cyc;
        check(ok && (t1 - t0) == 10, "R8 running period kept", t1 - t0, 10);
        measure(hi, lo, ok);
        check(ok && hi == 2 && lo == 2, "R8 new ratio used", hi * 256 + lo, 2 * 256 + 2);

        // R4 stop during run: output parks low
        write_reg(32'h0000_0100);
        check(rd_data == 32'h0000_013F, "R6 stop from run", rd_data, 32'h13F);
        repeat (20) @(negedge clk);
        low_ok = 1'b1;
        repeat (400) begin @(negedge clk); if (div_out !== 1'b0) low_ok = 1'b0; end
        check(low_ok, "R4 held low after stop", div_out, 0);
        run_and_check(5, 1, "R4 resume after stop");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule